// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block models the command state machine that sits behind the write port of a parallel NOR flash. A bus front end hands it decoded write cycles (address plus data) and read strobes. The block recognises the multi-cycle unlock sequences that start a program, a sector or whole-array erase, an identifier query, an erase suspend or resume, and a fast-program mode that needs only two cycles per program. It holds a small internal array that stands in for the flash cells, and it decides what each read returns: array contents, identifier codes or an operation status byte.

Embedded program and erase operations take a parameterised number of clock cycles. During that time a ready flag stays low and status reads report a complement-of-data bit and a bit that flips on every status read, so software can poll for completion. Sector protection is a static parameter mask. The unlock addresses, unlock data, identifier codes and operation durations are all parameters.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode with no command required; every array location reads all ones (FFh) before it is first programmed.
- R2: A program takes four writes: UNLK_DATA1 at UNLK_ADDR1, UNLK_DATA2 at UNLK_ADDR2, A0h at UNLK_ADDR1, then the data at the target address. Writing 20h at UNLK_ADDR1 after the two unlock writes enters fast-program mode, where A0h at any address followed by the data programs; 90h then 00h leaves that mode.
- R3: While an operation runs, a read returns a status byte: bit 7 is the inverse of bit 7 of the data being programmed (0 during an erase) and bit 6 inverts on each successive status read.
- R4: The `ready` output is 0 while a program or erase is running and 1 once it finishes.
- R5: Asserting reset aborts any running operation, leaving the array untouched by it; after reset is released `ready` stays 0 for exactly RST_CYC clock cycles.
- R6: After the unlock writes and 90h at UNLK_ADDR1, reads with address bit 0 = 1 return DEV_ID (DAh), reads with bits 1 and 0 both 0 return MFR_ID (01h); writing F0h returns to array reads.
- R7: In identifier mode a read with address bit 1 = 1 and bit 0 = 0 returns 01h when the sector selected by the top SW address bits is protected and 00h otherwise.
- R8: Writing B0h during an erase suspends it: `ready` returns to 1, the erase does not complete, other sectors can be read and programmed; writing 30h resumes the erase, which then completes.
- R9: A program or erase aimed at a sector set in PROT_MASK has no effect on the array and `ready` stays 1.
- R10: Programming can only clear bits (new value = old AND data); an erase sets every location of the chosen sector, or of all unprotected sectors for 10h at UNLK_ADDR1, to all ones.
- R11: A write that breaks a command sequence returns the controller to array reads without changing the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe |
| wr_addr | input | AW | Write cycle address |
| wr_data | input | DW | Write cycle data |
| rd_en | input | 1 | Read strobe; data appears on rd_data the next cycle |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read result (array, identifier or status) |
| ready | output | 1 | 1 when no embedded operation or reset recovery is running |

## Verification
On every cycle the assertions check that `ready` is low whenever either operation timer is running outside a suspend, that a suspended erase never completes, and that no program or erase strobe ever reaches a protected sector. The bench scenarios show the behaviours that depend on command order and data: the unlock sequences and fast-program entry and exit, the status bit values and their alternation, identifier and protection codes, the AND-only programming rule, sector-confined erase around a suspend, the exact reset recovery length, and that broken sequences leave the array unchanged.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_INIT,   // reset recovery
        ST_READ,   // array read, idle
        ST_UNL1,   // first unlock seen
        ST_UNL2,   // second unlock seen
        ST_PDATA,  // waiting for program data
        ST_PBUSY,  // embedded program running
        ST_ES0,    // erase setup seen
        ST_ES1,    // erase: first unlock again
        ST_ES2,    // erase: second unlock again
        ST_EBUSY,  // embedded erase running
        ST_SUSP,   // erase on hold
        ST_AUTO,   // identifier mode
        ST_BYP,    // fast-program mode idle
        ST_BEXIT   // fast-program exit pending
    } fcc_state_e;

    localparam logic [7:0] OP_PROGRAM = 8'hA0;
    localparam logic [7:0] OP_ESETUP  = 8'h80;
    localparam logic [7:0] OP_CHIP    = 8'h10;
    localparam logic [7:0] OP_SECTOR  = 8'h30;
    localparam logic [7:0] OP_RESUME  = 8'h30;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_EXIT    = 8'hF0;
    localparam logic [7:0] OP_SUSPEND = 8'hB0;
    localparam logic [7:0] OP_FASTPGM = 8'h20;
    localparam logic [7:0] OP_FASTEND = 8'h00;

endpackage

// File: rtl/fcc_timer.sv
module fcc_timer #(
    parameter int CW       = 8,
    parameter int LOAD     = 10,
    parameter int RST_LOAD = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    output logic busy,
    output logic done
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } tmr_t;

    tmr_t q, d;

    assign done = q.run && !hold && (q.cnt == CW'(1));
    assign busy = q.run;

    always_comb begin
        d = q;
        if (start) begin
            d.cnt = CW'(LOAD);
            d.run = 1'b1;
        end else if (q.run && !hold) begin
            if (q.cnt == CW'(1)) begin
                d.cnt = '0;
                d.run = 1'b0;
            end else begin
                d.cnt = q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= CW'(RST_LOAD);
            q.run <= (RST_LOAD != 0);
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic                  clk,
    input  logic [AW-1:0]         rd_addr,
    output logic [DW-1:0]         rd_data,
    input  logic                  prog_en,
    input  logic [AW-1:0]         prog_addr,
    input  logic [DW-1:0]         prog_data,
    input  logic                  erase_en,
    input  logic [(1<<SW)-1:0]    erase_mask
);
    localparam int DEPTH = 1 << AW;
    localparam int SBITS = AW - SW;

    // cells start erased
    logic [DW-1:0] cell_q [DEPTH] = '{default: '1};

    assign rd_data = cell_q[rd_addr];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (erase_en && erase_mask[i >> SBITS]) begin
                cell_q[i] <= '1;
            end else if (prog_en && (prog_addr == AW'(i))) begin
                cell_q[i] <= cell_q[i] & prog_data;
            end
        end
    end
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
    import flash_cmd_pkg::*;
#(
    parameter int               AW = 6,
    parameter int               DW = 8,
    parameter int               SW = 2,
    parameter logic [(1<<SW)-1:0] PROT_MASK = '0,
    parameter logic [AW-1:0]    UA1 = '0,
    parameter logic [AW-1:0]    UA2 = '0,
    parameter logic [7:0]       UD1 = 8'hAA,
    parameter logic [7:0]       UD2 = 8'h55,
    parameter logic [DW-1:0]    MFR_ID = '0,
    parameter logic [DW-1:0]    DEV_ID = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data,
    input  logic                  rd_en,
    input  logic                  rd_a0,
    input  logic                  rd_a1,
    input  logic [SW-1:0]         rd_sect,
    input  logic [DW-1:0]         arr_rdata,
    input  logic                  ptmr_done,
    input  logic                  etmr_done,
    output logic                  ptmr_start,
    output logic                  etmr_start,
    output logic                  etmr_hold,
    output logic                  prog_en,
    output logic [AW-1:0]         prog_addr,
    output logic [DW-1:0]         prog_data,
    output logic                  erase_en,
    output logic [(1<<SW)-1:0]    erase_mask,
    output logic [DW-1:0]         rd_data,
    output logic                  ready,
    output logic                  susp
);
    localparam int NSECT = 1 << SW;

    typedef struct packed {
        fcc_state_e       st;
        logic             fast;
        logic             susp;
        logic [AW-1:0]    laddr;
        logic [DW-1:0]    ldata;
        logic [NSECT-1:0] emask;
        logic             tog;
        logic [DW-1:0]    rdata;
    } seq_t;

    seq_t q, d;

    logic [7:0]       cmd;
    logic [SW-1:0]    wsect;
    logic             at1, at2;
    logic [NSECT-1:0] pick;
    logic             busy_st;
    fcc_state_e       home;

    assign prog_addr  = q.laddr;
    assign prog_data  = q.ldata;
    assign erase_mask = q.emask;
    assign rd_data    = q.rdata;
    assign susp       = q.susp;
    assign etmr_hold  = q.susp;
    assign busy_st    = (q.st == ST_PBUSY) || (q.st == ST_EBUSY);
    assign ready      = !(busy_st || (q.st == ST_INIT));

    always_comb begin
        d          = q;
        ptmr_start = 1'b0;
        etmr_start = 1'b0;
        prog_en    = 1'b0;
        erase_en   = 1'b0;
        cmd        = wr_data[7:0];
        wsect      = wr_addr[AW-1 -: SW];
        at1        = (wr_addr == UA1);
        at2        = (wr_addr == UA2);
        pick       = '0;
        home       = q.susp ? ST_SUSP : (q.fast ? ST_BYP : ST_READ);

        case (q.st)
            ST_INIT: if (ptmr_done) d.st = ST_READ;
            ST_READ: if (wr_en && at1 && cmd == UD1) d.st = ST_UNL1;
            ST_UNL1: if (wr_en) d.st = (at2 && cmd == UD2) ? ST_UNL2 : home;
            ST_UNL2: if (wr_en) begin
                d.st = home;
                if (at1 && cmd == OP_PROGRAM) begin
                    d.st = ST_PDATA;
                end else if (at1 && !q.susp && cmd == OP_IDENT) begin
                    d.st = ST_AUTO;
                end else if (at1 && !q.susp && cmd == OP_ESETUP) begin
                    d.st = ST_ES0;
                end else if (at1 && !q.susp && cmd == OP_FASTPGM) begin
                    d.st   = ST_BYP;
                    d.fast = 1'b1;
                end
            end
            ST_PDATA: if (wr_en) begin
                d.laddr = wr_addr;
                d.ldata = wr_data;
                if (!PROT_MASK[wsect] && !(q.susp && q.emask[wsect])) begin
                    d.st       = ST_PBUSY;
                    ptmr_start = 1'b1;
                end else begin
                    d.st = home;
                end
            end
            ST_PBUSY: if (ptmr_done) begin
                prog_en = 1'b1;
                d.st    = home;
            end
            ST_ES0: if (wr_en) d.st = (at1 && cmd == UD1) ? ST_ES1 : home;
            ST_ES1: if (wr_en) d.st = (at2 && cmd == UD2) ? ST_ES2 : home;
            ST_ES2: if (wr_en) begin
                if (at1 && cmd == OP_CHIP) begin
                    pick = ~PROT_MASK;
                end else if (cmd == OP_SECTOR) begin
                    pick = (NSECT'(1) << wsect) & ~PROT_MASK;
                end
                if (pick != '0) begin
                    d.emask    = pick;
                    d.st       = ST_EBUSY;
                    etmr_start = 1'b1;
                end else begin
                    d.st = home;
                end
            end
            ST_EBUSY: begin
                if (etmr_done) begin
                    erase_en = 1'b1;
                    d.emask  = '0;
                    d.st     = ST_READ;
                end else if (wr_en && cmd == OP_SUSPEND) begin
                    d.susp = 1'b1;
                    d.st   = ST_SUSP;
                end
            end
            ST_SUSP: if (wr_en) begin
                if (cmd == OP_RESUME) begin
                    d.susp = 1'b0;
                    d.st   = ST_EBUSY;
                end else if (at1 && cmd == UD1) begin
                    d.st = ST_UNL1;
                end
            end
            ST_AUTO: if (wr_en && cmd == OP_EXIT) d.st = ST_READ;
            ST_BYP: if (wr_en) begin
                if (cmd == OP_PROGRAM)    d.st = ST_PDATA;
                else if (cmd == OP_IDENT) d.st = ST_BEXIT;
            end
            ST_BEXIT: if (wr_en) begin
                if (cmd == OP_FASTEND) begin
                    d.fast = 1'b0;
                    d.st   = ST_READ;
                end else begin
                    d.st = ST_BYP;
                end
            end
            default: d.st = ST_READ;
        endcase

        // read return path
        if (rd_en) begin
            if (busy_st) begin
                d.rdata    = '0;
                d.rdata[7] = (q.st == ST_PBUSY) ? ~q.ldata[7] : 1'b0;
                d.rdata[6] = q.tog;
                d.tog      = ~q.tog;
            end else if (q.st == ST_AUTO) begin
                if (rd_a0)      d.rdata = DEV_ID;
                else if (rd_a1) d.rdata = DW'(PROT_MASK[rd_sect]);
                else            d.rdata = MFR_ID;
            end else begin
                d.rdata = arr_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_INIT;
            q.fast  <= 1'b0;
            q.susp  <= 1'b0;
            q.laddr <= '0;
            q.ldata <= '0;
            q.emask <= '0;
            q.tog   <= 1'b0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
    parameter int                 AW         = 6,
    parameter int                 DW         = 8,
    parameter int                 SW         = 2,
    parameter logic [(1<<SW)-1:0] PROT_MASK  = 4'b1000,
    parameter logic [AW-1:0]      UNLK_ADDR1 = 'h15,
    parameter logic [AW-1:0]      UNLK_ADDR2 = 'h2A,
    parameter logic [7:0]         UNLK_DATA1 = 8'hAA,
    parameter logic [7:0]         UNLK_DATA2 = 8'h55,
    parameter logic [DW-1:0]      MFR_ID     = 'h01,
    parameter logic [DW-1:0]      DEV_ID     = 'hDA,
    parameter int                 PGM_CYC    = 12,
    parameter int                 ERS_CYC    = 60,
    parameter int                 RST_CYC    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          ready
);
    localparam int NSECT = 1 << SW;
    localparam int MAXC  = (PGM_CYC > ERS_CYC) ?
                           ((PGM_CYC > RST_CYC) ? PGM_CYC : RST_CYC) :
                           ((ERS_CYC > RST_CYC) ? ERS_CYC : RST_CYC);
    localparam int CW    = $clog2(MAXC + 1);

    logic             ptmr_start, ptmr_busy, ptmr_done;
    logic             etmr_start, etmr_hold, etmr_busy, etmr_done;
    logic             prog_en, erase_en, susp;
    logic [AW-1:0]    prog_addr;
    logic [DW-1:0]    prog_data, arr_rdata;
    logic [NSECT-1:0] erase_mask;

    // program timer doubles as reset-recovery timer
    fcc_timer #(.CW(CW), .LOAD(PGM_CYC), .RST_LOAD(RST_CYC)) u_ptmr (
        .clk(clk), .rst_n(rst_n), .start(ptmr_start), .hold(1'b0),
        .busy(ptmr_busy), .done(ptmr_done)
    );

    fcc_timer #(.CW(CW), .LOAD(ERS_CYC), .RST_LOAD(0)) u_etmr (
        .clk(clk), .rst_n(rst_n), .start(etmr_start), .hold(etmr_hold),
        .busy(etmr_busy), .done(etmr_done)
    );

    fcc_array #(.AW(AW), .DW(DW), .SW(SW)) u_array (
        .clk(clk), .rd_addr(rd_addr), .rd_data(arr_rdata),
        .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_en(erase_en), .erase_mask(erase_mask)
    );

    fcc_seq #(
        .AW(AW), .DW(DW), .SW(SW), .PROT_MASK(PROT_MASK),
        .UA1(UNLK_ADDR1), .UA2(UNLK_ADDR2), .UD1(UNLK_DATA1), .UD2(UNLK_DATA2),
        .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_a0(rd_addr[0]), .rd_a1(rd_addr[1]),
        .rd_sect(rd_addr[AW-1 -: SW]), .arr_rdata(arr_rdata),
        .ptmr_done(ptmr_done), .etmr_done(etmr_done),
        .ptmr_start(ptmr_start), .etmr_start(etmr_start), .etmr_hold(etmr_hold),
        .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_en(erase_en), .erase_mask(erase_mask),
        .rd_data(rd_data), .ready(ready), .susp(susp)
    );
endmodule

// File: rtl/fcc_chk.sv
module fcc_chk #(
    parameter int                 SW        = 2,
    parameter logic [(1<<SW)-1:0] PROT_MASK = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               susp,
    input logic               ptmr_busy,
    input logic               etmr_busy,
    input logic               etmr_done,
    input logic               prog_en,
    input logic [SW-1:0]      prog_sect,
    input logic               erase_en,
    input logic [(1<<SW)-1:0] erase_mask
);
    // R4
    prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptmr_busy |-> !ready);

    // R4
    erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (etmr_busy && !susp) |-> !ready);

    // R8
    susp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp |-> !etmr_done);

    // R8
    susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp && !ptmr_busy) |-> ready);

    // R9
    prot_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> !PROT_MASK[prog_sect]);

    // R9
    prot_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |-> ((erase_mask & PROT_MASK) == '0));
endmodule

bind flash_cmd_ctrl fcc_chk #(.SW(SW), .PROT_MASK(PROT_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .susp(susp),
    .ptmr_busy(ptmr_busy), .etmr_busy(etmr_busy), .etmr_done(etmr_done),
    .prog_en(prog_en), .prog_sect(prog_addr[AW-1 -: SW]),
    .erase_en(erase_en), .erase_mask(erase_mask)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
    localparam int         AW      = 6;
    localparam int         DW      = 8;
    localparam int         RST_CYC = 5;
    localparam logic [5:0] UA1     = 6'h15;
    localparam logic [5:0] UA2     = 6'h2A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          ready;

    flash_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ready(ready)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    logic  sb_flag = 1'b0;
    logic  armed   = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (armed) begin
            if (q.size() == 0) begin
                chk(1'b0, "scoreboard underrun", rd_data, 8'h00);
            end else begin
                item_t it;
                it = q.pop_front();
                chk((((rd_data ^ it.exp) & it.mask) == 8'h00), it.tag, rd_data, it.exp);
            end
        end
        armed = sb_flag;
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] dat);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = dat;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(UA1, 8'hAA);
        wr(UA2, 8'h55);
    endtask

    task automatic rd_exp(input logic [5:0] a, input logic [7:0] exp,
                          input logic [7:0] mask, input string tag);
        item_t it;
        it.exp = exp; it.mask = mask; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #2;
        rd_en = 1'b1; rd_addr = a; sb_flag = 1'b1;
        @(posedge clk); #2;
        rd_en = 1'b0; sb_flag = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_now(input logic [5:0] a, output logic [7:0] v);
        @(posedge clk); #2;
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); #2;
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        while (!ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(ready === 1'b1, tag, {7'b0, ready}, 8'h01);
    endtask

    task automatic reset_release(input string tag);
        int lows = 0;
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        while (!ready && lows < 100) begin
            lows++;
            @(negedge clk);
        end
        chk(lows == RST_CYC, tag, 8'(lows), 8'(RST_CYC));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog expired", 8'h00, 8'h01);
        finish_run();
    end

    initial begin
        logic [7:0] s1, s2;
        repeat (3) @(posedge clk);

        // R5: recovery length after reset; R1: array reads need no command
        reset_release("R5 reset recovery cycles");
        rd_exp(6'h00, 8'hFF, 8'hFF, "R1 erased array after reset");
        rd_exp(6'h3F, 8'hFF, 8'hFF, "R1 erased top location");

        // R2: four-cycle program, R4 busy, R3 status
        unlock();
        wr(UA1, 8'hA0);
        wr(6'h03, 8'h5A);
        chk(ready == 1'b0, "R4 ready low during program", {7'b0, ready}, 8'h00);
        rd_exp(6'h03, 8'h80, 8'h80, "R3 DQ7 inverse of data bit7");
        rd_now(6'h03, s1);
        rd_now(6'h03, s2);
        chk(s1[6] != s2[6], "R3 DQ6 alternates", s2, ~s1);
        wait_ready("R4 ready after program");
        rd_exp(6'h03, 8'h5A, 8'hFF, "R2 programmed value");

        // R10: program only clears bits
        unlock(); wr(UA1, 8'hA0); wr(6'h03, 8'h0F);
        wait_ready("R4 ready after second program");
        rd_exp(6'h03, 8'h0A, 8'hFF, "R10 AND of old and new");

        // R11: broken sequence
        unlock();
        wr(UA1, 8'h12);
        wr(6'h04, 8'h00);
        chk(ready == 1'b1, "R11 no operation started", {7'b0, ready}, 8'h01);
        wr(UA1, 8'hA0);
        wr(6'h04, 8'h00);
        rd_exp(6'h04, 8'hFF, 8'hFF, "R11 array untouched");

        // R6 / R7: identifier mode
        unlock(); wr(UA1, 8'h90);
        rd_exp(6'h00, 8'h01, 8'hFF, "R6 manufacturer code");
        rd_exp(6'h01, 8'hDA, 8'hFF, "R6 device code");
        rd_exp(6'h32, 8'h01, 8'hFF, "R7 protected sector 3");
        rd_exp(6'h02, 8'h00, 8'hFF, "R7 unprotected sector 0");
        wr(6'h00, 8'hF0);
        rd_exp(6'h03, 8'h0A, 8'hFF, "R6 exit back to array");

        // R9: protected sector
        unlock(); wr(UA1, 8'hA0); wr(6'h30, 8'h00);
        chk(ready == 1'b1, "R9 program of protected sector ignored", {7'b0, ready}, 8'h01);
        rd_exp(6'h30, 8'hFF, 8'hFF, "R9 protected location unchanged");
        unlock(); wr(UA1, 8'h80); unlock(); wr(6'h30, 8'h30);
        chk(ready == 1'b1, "R9 erase of protected sector ignored", {7'b0, ready}, 8'h01);

        // R2: fast-program mode
        unlock(); wr(UA1, 8'h20);
        wr(6'h07, 8'hA0);
        wr(6'h10, 8'h33);
        wait_ready("R2 fast program done");
        rd_exp(6'h10, 8'h33, 8'hFF, "R2 fast program two cycles");
        wr(6'h00, 8'h90);
        wr(6'h00, 8'h00);
        wr(UA1, 8'hA0);
        wr(6'h11, 8'h44);
        chk(ready == 1'b1, "R2 fast mode left", {7'b0, ready}, 8'h01);
        rd_exp(6'h11, 8'hFF, 8'hFF, "R2 two-cycle program rejected after exit");

        // R8: sector erase with suspend / resume
        unlock(); wr(UA1, 8'h80); unlock(); wr(6'h00, 8'h30);
        chk(ready == 1'b0, "R4 ready low during erase", {7'b0, ready}, 8'h00);
        rd_exp(6'h00, 8'h00, 8'h80, "R3 DQ7 zero during erase");
        wr(6'h00, 8'hB0);
        chk(ready == 1'b1, "R8 ready after suspend", {7'b0, ready}, 8'h01);
        repeat (100) @(negedge clk);
        rd_exp(6'h03, 8'h0A, 8'hFF, "R8 erase held while suspended");
        rd_exp(6'h10, 8'h33, 8'hFF, "R8 read other sector while suspended");
        unlock(); wr(UA1, 8'hA0); wr(6'h12, 8'h21);
        wait_ready("R8 program during suspend done");
        rd_exp(6'h12, 8'h21, 8'hFF, "R8 program during suspend");
        wr(6'h00, 8'h30);
        chk(ready == 1'b0, "R8 erase resumed", {7'b0, ready}, 8'h00);
        wait_ready("R8 erase completes");
        rd_exp(6'h03, 8'hFF, 8'hFF, "R10 erased sector all ones");
        rd_exp(6'h10, 8'h33, 8'hFF, "R10 other sector kept");

        // R5: reset aborts a running program
        unlock(); wr(UA1, 8'hA0); wr(6'h20, 8'h00);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        reset_release("R5 recovery after abort");
        rd_exp(6'h20, 8'hFF, 8'hFF, "R5 aborted program leaves array");
        rd_exp(6'h12, 8'h21, 8'hFF, "R5 array kept across reset");

        // R10: whole-array erase
        unlock(); wr(UA1, 8'h80); unlock(); wr(UA1, 8'h10);
        wait_ready("R10 chip erase done");
        rd_exp(6'h10, 8'hFF, 8'hFF, "R10 chip erase sector1");
        rd_exp(6'h12, 8'hFF, 8'hFF, "R10 chip erase sector1 second word");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule